// File: doc/BRIEF.md
# Reference Clock Validity Qualifier

The block decides, for five reference clock inputs, whether each input can be trusted. An upstream quality monitor supplies alarm and measurement flags for every input. The block combines these flags with a few configuration enables into two registered validity vectors. The secondary view applies only the basic conditions. The main view adds two extra conditions, and it applies them only to the input that the main path has currently selected.

Every change of an input's main-view validity is caught in a sticky change flag. When a per-input enable is set, that flag raises the interrupt. When the selected main-path input goes from valid to invalid, a sticky failure flag is set. That flag can raise the interrupt, and it can also drive a dedicated output pin, which stays high until software clears the flag. All flags are cleared by write-one-to-clear strobes.

Top module: `refq_top`

## Requirements
- R1: The secondary validity bit of input i is 1 exactly when its no-activity alarm and its frequency hard alarm are both 0 (and R2 holds). It appears one clock edge after the inputs.
- R2: When `noiseWinEn` is 1, an input with `lowRateRef` = 1 and `edgesInWindow` = 0 is invalid in both views. When `noiseWinEn` is 0, `lowRateRef` and `edgesInWindow` have no effect.
- R3: For the input whose index equals `mainSel` (values 0 to 4), the main validity bit also needs `phaseLockAlarm` = 0. For every other input, and for all inputs when `mainSel` is 5 to 7, the main bit equals the secondary bit.
- R4: When `ultraFastEn` is 1, the selected input is invalid in the main view while `missedTwo` is 1. When `ultraFastEn` is 0, `missedTwo` has no effect.
- R5: Any change of a main validity bit, in either direction, sets that input's sticky `chgFlag` bit at the same edge. `irq` is 1 while any `chgFlag` bit is 1 with its `chgIrqEn` bit set.
- R6: `failFlag` is set when the main bit of the selected input goes from 1 to 0 while `mainSel` has held the same in-range value for two consecutive cycles. `irq` is also 1 while `failFlag` and `failIrqEn` are both 1.
- R7: `failPin` is 1 exactly while `failFlag`, `failIrqEn` and `pinRouteEn` are all 1, so it stays high until the flag is cleared.
- R8: A 1 on `chgClr` bit i or on `failClr` clears the matching flag at the next edge. A set event in the same cycle wins over the clear.
- R9: After reset, every validity bit, every flag, `irq` and `failPin` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| noActAlarm | input | 5 | Per-input no-activity alarm |
| freqHardAlarm | input | 5 | Per-input frequency hard alarm |
| lowRateRef | input | 5 | Input runs at 2, 4 or 8 kHz |
| edgesInWindow | input | 5 | All edges within ±5% drift |
| phaseLockAlarm | input | 5 | Per-input phase-lock alarm |
| missedTwo | input | 5 | Input missed two or more consecutive cycles |
| mainSel | input | 3 | Index of the main-path selected input |
| noiseWinEn | input | 1 | Enables the drift-window condition |
| ultraFastEn | input | 1 | Enables the missed-cycle condition |
| chgIrqEn | input | 5 | Per-input change interrupt enable |
| failIrqEn | input | 1 | Failure interrupt enable |
| pinRouteEn | input | 1 | Routes the failure interrupt to `failPin` |
| chgClr | input | 5 | Write-one-to-clear strobes for `chgFlag` |
| failClr | input | 1 | Write-one-to-clear strobe for `failFlag` |
| validSec | output | 5 | Registered secondary-view validity |
| validMain | output | 5 | Registered main-view validity |
| chgFlag | output | 5 | Sticky validity-change flags |
| failFlag | output | 1 | Sticky main-reference-failed flag |
| irq | output | 1 | Combined interrupt |
| failPin | output | 1 | Failure indication pin |

## Verification
Both validity views and all sticky flags update at the first rising edge after an input pattern is applied. `irq` and `failPin` are decoded combinationally from those registers, so they change in that same cycle. The bench applies each pattern on a falling edge, updates its arithmetic model once for the next rising edge, and compares every output on the following falling edge, before the next pattern is driven. Clears and set events therefore meet in one sampled cycle, which is the case R8 requires.

// File: rtl/refq_pkg.sv
package refq_pkg;
  localparam int NUM_REF = 5;

  typedef struct packed {
    logic [NUM_REF-1:0] chgSet;
    logic [NUM_REF-1:0] chgClr;
    logic               failSet;
    logic               failClr;
  } refqStrobe_t;
endpackage

// File: rtl/refq_qualify.sv
module refq_qualify #(
  parameter int NUM_REF = refq_pkg::NUM_REF,
  parameter int SEL_W   = $clog2(NUM_REF)
) (
  input  logic [NUM_REF-1:0] noActAlarm,
  input  logic [NUM_REF-1:0] freqHardAlarm,
  input  logic [NUM_REF-1:0] lowRateRef,
  input  logic [NUM_REF-1:0] edgesInWindow,
  input  logic [NUM_REF-1:0] phaseLockAlarm,
  input  logic [NUM_REF-1:0] missedTwo,
  input  logic [SEL_W-1:0]   mainSel,
  input  logic               noiseWinEn,
  input  logic               ultraFastEn,
  output logic [NUM_REF-1:0] nextSec,
  output logic [NUM_REF-1:0] nextMain
);
  // One identical qualification slice per reference input.
  for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
    logic noiseBad;
    logic isSel;
    logic mainBad;
    assign noiseBad    = noiseWinEn & lowRateRef[i] & ~edgesInWindow[i];
    assign nextSec[i]  = ~noActAlarm[i] & ~freqHardAlarm[i] & ~noiseBad;
    assign isSel       = (mainSel == SEL_W'(i));
    assign mainBad     = isSel & (phaseLockAlarm[i] | (ultraFastEn & missedTwo[i]));
    assign nextMain[i] = nextSec[i] & ~mainBad;
  end
endmodule

// File: rtl/refq_ctrl.sv
module refq_ctrl
  import refq_pkg::*;
#(
  parameter int NUM_REF = refq_pkg::NUM_REF,
  parameter int SEL_W   = $clog2(NUM_REF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] nextMain,
  input  logic [NUM_REF-1:0] validMain,
  input  logic [SEL_W-1:0]   mainSel,
  input  logic [NUM_REF-1:0] chgClr,
  input  logic               failClr,
  output refqStrobe_t        strobe
);
  logic [SEL_W-1:0] selPrev;
  logic             selInRange;
  logic             selOld;
  logic             selNew;

  always_comb begin
    selInRange = 1'b0;
    selOld     = 1'b0;
    selNew     = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (mainSel == SEL_W'(i)) begin
        selInRange = 1'b1;
        selOld     = validMain[i];
        selNew     = nextMain[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selPrev <= '0;
    else       selPrev <= mainSel;
  end

  always_comb begin
    strobe.chgSet  = nextMain ^ validMain;
    strobe.chgClr  = chgClr;
    strobe.failSet = selInRange & (selPrev == mainSel) & selOld & ~selNew;
    strobe.failClr = failClr;
  end
endmodule

// File: rtl/refq_regs.sv
module refq_regs
  import refq_pkg::*;
#(
  parameter int NUM_REF = refq_pkg::NUM_REF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] nextSec,
  input  logic [NUM_REF-1:0] nextMain,
  input  refqStrobe_t        strobe,
  input  logic [NUM_REF-1:0] chgIrqEn,
  input  logic               failIrqEn,
  input  logic               pinRouteEn,
  output logic [NUM_REF-1:0] validSec,
  output logic [NUM_REF-1:0] validMain,
  output logic [NUM_REF-1:0] chgFlag,
  output logic               failFlag,
  output logic               irq,
  output logic               failPin
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validSec  <= '0;
      validMain <= '0;
      chgFlag   <= '0;
      failFlag  <= 1'b0;
    end else begin
      validSec  <= nextSec;
      validMain <= nextMain;
      chgFlag   <= (chgFlag & ~strobe.chgClr) | strobe.chgSet;
      failFlag  <= (failFlag & ~strobe.failClr) | strobe.failSet;
    end
  end

  assign irq     = (|(chgFlag & chgIrqEn)) | (failFlag & failIrqEn);
  assign failPin = failFlag & failIrqEn & pinRouteEn;

  AST_MAIN_WITHIN_SEC: assert property (@(posedge clk) disable iff (!rstN)
    ((validMain & ~validSec) == '0) && ($countones(validMain ^ validSec) <= 1)) else $error("AST_MAIN_WITHIN_SEC"); // R3
  AST_CHG_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    ((chgFlag & ~$past(chgFlag)) & ~(validMain ^ $past(validMain))) == '0) else $error("AST_CHG_ON_EDGE"); // R5
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlag & $past(chgFlag & ~strobe.chgClr)) == $past(chgFlag & ~strobe.chgClr)) else $error("AST_CHG_STICKY"); // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(failFlag & ~strobe.failClr) |-> failFlag) else $error("AST_FAIL_STICKY"); // R8
endmodule

// File: rtl/refq_top.sv
module refq_top
  import refq_pkg::*;
#(
  parameter int NUM_REF = refq_pkg::NUM_REF,
  localparam int SEL_W  = $clog2(NUM_REF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] noActAlarm,
  input  logic [NUM_REF-1:0] freqHardAlarm,
  input  logic [NUM_REF-1:0] lowRateRef,
  input  logic [NUM_REF-1:0] edgesInWindow,
  input  logic [NUM_REF-1:0] phaseLockAlarm,
  input  logic [NUM_REF-1:0] missedTwo,
  input  logic [SEL_W-1:0]   mainSel,
  input  logic               noiseWinEn,
  input  logic               ultraFastEn,
  input  logic [NUM_REF-1:0] chgIrqEn,
  input  logic               failIrqEn,
  input  logic               pinRouteEn,
  input  logic [NUM_REF-1:0] chgClr,
  input  logic               failClr,
  output logic [NUM_REF-1:0] validSec,
  output logic [NUM_REF-1:0] validMain,
  output logic [NUM_REF-1:0] chgFlag,
  output logic               failFlag,
  output logic               irq,
  output logic               failPin
);
  logic [NUM_REF-1:0] nextSec;
  logic [NUM_REF-1:0] nextMain;
  refqStrobe_t        strobe;

  refq_qualify #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) i_qualify (
    .noActAlarm(noActAlarm), .freqHardAlarm(freqHardAlarm),
    .lowRateRef(lowRateRef), .edgesInWindow(edgesInWindow),
    .phaseLockAlarm(phaseLockAlarm), .missedTwo(missedTwo),
    .mainSel(mainSel), .noiseWinEn(noiseWinEn), .ultraFastEn(ultraFastEn),
    .nextSec(nextSec), .nextMain(nextMain)
  );

  refq_ctrl #(.NUM_REF(NUM_REF), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .nextMain(nextMain), .validMain(validMain),
    .mainSel(mainSel), .chgClr(chgClr), .failClr(failClr), .strobe(strobe)
  );

  refq_regs #(.NUM_REF(NUM_REF)) i_regs (
    .clk(clk), .rstN(rstN), .nextSec(nextSec), .nextMain(nextMain),
    .strobe(strobe), .chgIrqEn(chgIrqEn), .failIrqEn(failIrqEn),
    .pinRouteEn(pinRouteEn), .validSec(validSec), .validMain(validMain),
    .chgFlag(chgFlag), .failFlag(failFlag), .irq(irq), .failPin(failPin)
  );

  logic selValidNow;
  always_comb begin
    selValidNow = 1'b0;
    for (int i = 0; i < NUM_REF; i++)
      if (mainSel == SEL_W'(i)) selValidNow = validMain[i];
  end

  AST_FAIL_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failFlag) |-> $past(selValidNow) &&
      ((validMain & (NUM_REF'(1) << $past(mainSel))) == '0)) else $error("AST_FAIL_ON_DROP"); // R6
  AST_PIN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(failPin) && !$past(strobe.failClr) && $stable(failIrqEn) && $stable(pinRouteEn)) |-> failPin) else $error("AST_PIN_HELD"); // R7
endmodule

// File: tb/test_refq_top.sv
`timescale 1ns/1ps
module test_refq_top;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] noActAlarm = '0, freqHardAlarm = '0, lowRateRef = '0, edgesInWindow = '0;
  logic [N-1:0] phaseLockAlarm = '0, missedTwo = '0, chgIrqEn = '0, chgClr = '0;
  logic [2:0]   mainSel = 3'd7;
  logic noiseWinEn = 1'b0, ultraFastEn = 1'b0, failIrqEn = 1'b0, pinRouteEn = 1'b0, failClr = 1'b0;
  logic [N-1:0] validSec, validMain, chgFlag;
  logic failFlag, irq, failPin;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [N-1:0] eSec = '0, eMain = '0, eChg = '0;
  logic eFail = 1'b0;
  logic [2:0] eSelPrev = '0;

  always #4 clk = ~clk;

  refq_top i_refq_top (
    .clk(clk), .rstN(rstN), .noActAlarm(noActAlarm), .freqHardAlarm(freqHardAlarm),
    .lowRateRef(lowRateRef), .edgesInWindow(edgesInWindow), .phaseLockAlarm(phaseLockAlarm),
    .missedTwo(missedTwo), .mainSel(mainSel), .noiseWinEn(noiseWinEn), .ultraFastEn(ultraFastEn),
    .chgIrqEn(chgIrqEn), .failIrqEn(failIrqEn), .pinRouteEn(pinRouteEn), .chgClr(chgClr),
    .failClr(failClr), .validSec(validSec), .validMain(validMain), .chgFlag(chgFlag),
    .failFlag(failFlag), .irq(irq), .failPin(failPin)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic expIrq;
    expIrq = (|(eChg & chgIrqEn)) | (eFail & failIrqEn);
    chk(tag, "validSec", validSec, eSec);
    chk(tag, "validMain", validMain, eMain);
    chk(tag, "chgFlag", chgFlag, eChg);
    chk(tag, "failFlag", failFlag, eFail);
    chk(tag, "irq", irq, expIrq);
    chk(tag, "failPin", failPin, eFail & failIrqEn & pinRouteEn);
  endtask

  // Called on a falling edge with inputs applied; model advances to the next rising edge.
  task automatic stepCheck(input string tag);
    logic [N-1:0] nSec, nMain;
    logic failSet;
    for (int i = 0; i < N; i++) begin
      nSec[i] = !noActAlarm[i] && !freqHardAlarm[i] &&
                !(noiseWinEn && lowRateRef[i] && !edgesInWindow[i]);
      nMain[i] = nSec[i] && !((int'(mainSel) == i) &&
                 (phaseLockAlarm[i] || (ultraFastEn && missedTwo[i])));
    end
    failSet = (int'(mainSel) < N) && (mainSel == eSelPrev) &&
              eMain[mainSel] && !nMain[mainSel];
    @(posedge clk);
    eChg = (eChg & ~chgClr) | (nMain ^ eMain);
    eFail = (eFail & ~failClr) | failSet;
    eSec = nSec;
    eMain = nMain;
    eSelPrev = mainSel;
    @(negedge clk);
    checkAll(tag);
  endtask

  function automatic logic [N-1:0] sparse();
    return N'($urandom) & N'($urandom);
  endfunction

  task automatic drive(input bit useNoise, input bit usePh, input bit useUf,
                       input bit randSel, input bit randCfg, input bit allClr);
    noActAlarm    = sparse();
    freqHardAlarm = sparse();
    lowRateRef    = N'($urandom);
    edgesInWindow = N'($urandom);
    noiseWinEn    = useNoise ? 1'($urandom) : 1'b0;
    phaseLockAlarm = usePh ? N'($urandom) : '0;
    missedTwo     = N'($urandom);
    ultraFastEn   = useUf ? 1'($urandom) : 1'b0;
    if (randSel && ($urandom % 4 == 0)) mainSel = 3'($urandom);
    chgIrqEn      = randCfg ? N'($urandom) : '0;
    failIrqEn     = randCfg ? 1'($urandom) : 1'b0;
    pinRouteEn    = randCfg ? 1'($urandom) : 1'b0;
    chgClr        = allClr ? '1 : (sparse() & sparse());
    failClr       = allClr ? 1'b1 : ($urandom % 8 == 0);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkAll("R9");
    rstN = 1'b1;
    // R1: basic alarms only, no selection, main view equals secondary view
    for (int k = 0; k < 300; k++) begin drive(0, 1, 1, 0, 0, 0); stepCheck("R1"); end
    // R2: drift-window condition toggled on and off
    for (int k = 0; k < 300; k++) begin drive(1, 0, 0, 0, 0, 0); stepCheck("R2"); end
    // R3: phase alarm with a moving selection
    for (int k = 0; k < 300; k++) begin drive(0, 1, 0, 1, 0, 0); stepCheck("R3"); end
    // R4: missed-cycle condition toggled on and off
    for (int k = 0; k < 300; k++) begin drive(0, 0, 1, 1, 0, 0); stepCheck("R4"); end
    // R5: change flags with interrupt enables
    for (int k = 0; k < 300; k++) begin drive(1, 1, 1, 1, 1, 0); stepCheck("R5"); end
    // R6: failures on a fixed selection
    mainSel = 3'd2;
    for (int k = 0; k < 300; k++) begin drive(1, 1, 1, 0, 1, 0); stepCheck("R6"); end
    // R7: pin routing, with flag held then cleared
    for (int k = 0; k < 300; k++) begin
      drive(1, 1, 1, 1, 1, 0);
      failClr = 1'b0;
      if (k % 50 == 49) failClr = 1'b1;
      stepCheck("R7");
    end
    // R8: clears every cycle; simultaneous set events must win
    for (int k = 0; k < 300; k++) begin drive(1, 1, 1, 0, 1, 1); stepCheck("R8"); end
    // R8: quiet inputs, clears wipe flags
    noActAlarm = '0; freqHardAlarm = '0; noiseWinEn = 0; ultraFastEn = 0; phaseLockAlarm = '0;
    chgClr = '0; failClr = 0;
    stepCheck("R8");
    chgClr = '1; failClr = 1;
    stepCheck("R8");
    chgClr = '0; failClr = 0;
    stepCheck("R8");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule